// File: doc/BRIEF.md
# Eight-channel edge-aligned PWM timer

This block produces eight pulse-width-modulated outputs from one shared up-counter, so all channels run at the same period and are phase-locked to the same period start. The counter is advanced by a selectable tick source: the core clock, a fixed-rate tick pulse or an external tick pulse. That tick passes through a power-of-two prescaler. The counter starts each period at a programmable initial value and wraps back to it after it reaches the modulo value. Each channel raises its output at the start of the period and drops it when the counter reaches the channel's compare value. A per-channel polarity bit, output mask and enable bit then shape the final pin level.

Software configures the block through a flat 32-bit register port with word-aligned byte addresses. A lock bit can be set to protect the configuration against stray writes. The output mask stays writable while the lock is set, so channels can be gated on and off without dropping the lock. Modulo and compare updates are held in pending registers and become active only at a period boundary.

Top module: `octa_pwm_timer`

## Requirements
- R1: After reset the mask register (byte address 0x14) reads 0xFF, the control register (0x00) reads 0, the modulo register (0x08) reads 0xFFFF, the lock status (0x1C, bit 0) reads 0, and every output is low.
- R2: Control bits [4:3] select the tick source. 0 stops the counter, 1 selects the core clock, 2 selects fixTick and 3 selects extTick. While the counter is stopped, the counter register (0x04, read-only) holds the counter-initial value from 0x0C.
- R3: While running, the counter counts from the counter-initial value up to the active modulo value and then wraps, so a period is MOD − CNTIN + 1 ticks.
- R4: Control bits [2:0] hold a prescale code ps. The counter advances once every 2^ps selected ticks.
- R5: With source 2 selected, the counter advances only on cycles where fixTick is high, and holds its value otherwise.
- R6: Channel compare registers are at 0x60 + 4·ch. A running channel is high (before polarity) while the counter is below its compare value. With CNTIN = 0, it is therefore high for exactly CMP ticks of each period.
- R7: A compare value of 0 gives a constant low level. A compare value greater than MOD gives a constant high level.
- R8: Polarity register bit ch (0x18) inverts channel ch's level.
- R9: An output is low whenever its mask bit (0x14) is set or its enable bit (control bit 16 + ch) is clear.
- R10: Writing 1 to bit 0 at 0x1C sets the lock, and writing 1 to bit 0 at 0x20 clears it. While locked, writes to 0x00, 0x08, 0x0C, 0x10, 0x18 and all channel registers are ignored, but the mask register stays writable.
- R11: A new modulo or compare value takes effect only when the counter wraps, or at once while the counter is stopped. The period in progress is never shortened.
- R12: While the counter is stopped, an enabled and unmasked channel outputs its output-init bit (0x10) XOR its polarity bit.
- R13: Channel control bit 0 (0x40 + 4·ch) selects PWM mode. When it is clear, the running channel's level is low before polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also tick source 1 |
| rstN | input | 1 | Active-low synchronous reset |
| fixTick | input | 1 | Fixed-rate tick pulse, source 2 |
| extTick | input | 1 | External tick pulse, source 3 |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 8 | Byte address, word aligned |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, combinational from busAddr |
| pwmOut | output | 8 | Channel outputs |

## Verification
A register write lands on the clock edge where busWr is sampled. A read is combinational, so the bench samples read data just after the falling edge that follows a write. Outputs are registered one cycle behind the counter. For that reason, duty is measured by counting high samples across one whole period in steady state, which makes the result independent of that one-cycle offset. Period and prescale are measured from one entry into counter value 0 to the next. The deferred-update check records the highest counter value seen between the modulo write and the next wrap, so an update that takes effect early shows up as a wrong maximum.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  localparam int NUM_CH = 8;
  localparam int CNT_W  = 16;
  localparam int PS_W   = 3;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  // register byte addresses
  localparam logic [7:0] A_CTRL   = 8'h00;
  localparam logic [7:0] A_CNT    = 8'h04;
  localparam logic [7:0] A_MOD    = 8'h08;
  localparam logic [7:0] A_CNTIN  = 8'h0C;
  localparam logic [7:0] A_OINIT  = 8'h10;
  localparam logic [7:0] A_MASK   = 8'h14;
  localparam logic [7:0] A_POL    = 8'h18;
  localparam logic [7:0] A_LOCK   = 8'h1C;
  localparam logic [7:0] A_UNLOCK = 8'h20;
  localparam logic [2:0] BANK_CHCTL = 3'd2; // 0x40..0x5C
  localparam logic [2:0] BANK_CMP   = 3'd3; // 0x60..0x7C

  // control register field positions
  localparam int F_PS  = 0;
  localparam int F_SRC = 3;
  localparam int F_EN  = 16;

  typedef struct packed {
    logic            running;
    logic [1:0]      srcSel;
    logic [PS_W-1:0] psSel;
  } dpCtl_t;
endpackage

// File: rtl/pwm8_ctrl.sv
module pwm8_ctrl
  import pwm8_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int CW  = CNT_W,
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic [AW-1:0]       busAddr,
  input  logic [DW-1:0]       busWData,
  output logic [DW-1:0]       busRData,
  input  logic [CW-1:0]       cntVal,
  output dpCtl_t              dpCtl,
  output logic [CW-1:0]       modReg,
  output logic [CW-1:0]       cntInit,
  output logic [NCH-1:0]      outInit,
  output logic [NCH-1:0]      maskReg,
  output logic [NCH-1:0]      polReg,
  output logic [NCH-1:0]      chEn,
  output logic [NCH-1:0]      chMode,
  output logic [NCH-1:0][CW:0] cmpReg,
  output logic                locked
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [PS_W-1:0] psReg;
  logic [1:0]      srcReg;
  logic [IDX_W-1:0] chIdx;
  logic [2:0]      bank;
  logic            inRange;

  assign chIdx   = busAddr[2 +: IDX_W];
  assign bank    = busAddr[7:5];
  assign inRange = (int'(chIdx) < NCH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psReg   <= '0;
      srcReg  <= '0;
      chEn    <= '0;
      modReg  <= '1;
      cntInit <= '0;
      outInit <= '0;
      maskReg <= '1;
      polReg  <= '0;
      chMode  <= '0;
      cmpReg  <= '0;
      locked  <= 1'b0;
    end else if (busWr) begin
      if (busAddr == A_LOCK && busWData[0])   locked  <= 1'b1;
      if (busAddr == A_UNLOCK && busWData[0]) locked  <= 1'b0;
      if (busAddr == A_MASK)                  maskReg <= busWData[NCH-1:0];
      if (!locked) begin
        case (busAddr)
          A_CTRL: begin
            psReg  <= busWData[F_PS +: PS_W];
            srcReg <= busWData[F_SRC +: 2];
            chEn   <= busWData[F_EN +: NCH];
          end
          A_MOD:   modReg  <= busWData[CW-1:0];
          A_CNTIN: cntInit <= busWData[CW-1:0];
          A_OINIT: outInit <= busWData[NCH-1:0];
          A_POL:   polReg  <= busWData[NCH-1:0];
          default: begin
            if (inRange && busAddr[1:0] == 2'b00) begin
              if (bank == BANK_CHCTL) chMode[chIdx] <= busWData[0];
              if (bank == BANK_CMP)   cmpReg[chIdx] <= busWData[CW:0];
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    busRData = '0;
    case (busAddr)
      A_CTRL: begin
        busRData[F_PS +: PS_W] = psReg;
        busRData[F_SRC +: 2]   = srcReg;
        busRData[F_EN +: NCH]  = chEn;
      end
      A_CNT:   busRData[CW-1:0]  = cntVal;
      A_MOD:   busRData[CW-1:0]  = modReg;
      A_CNTIN: busRData[CW-1:0]  = cntInit;
      A_OINIT: busRData[NCH-1:0] = outInit;
      A_MASK:  busRData[NCH-1:0] = maskReg;
      A_POL:   busRData[NCH-1:0] = polReg;
      A_LOCK:  busRData[0]       = locked;
      default: begin
        if (inRange && bank == BANK_CHCTL) busRData[0]    = chMode[chIdx];
        if (inRange && bank == BANK_CMP)   busRData[CW:0] = cmpReg[chIdx];
      end
    endcase
  end

  assign dpCtl.running = (srcReg != 2'd0);
  assign dpCtl.srcSel  = srcReg;
  assign dpCtl.psSel   = psReg;
endmodule

// File: rtl/pwm8_datapath.sv
module pwm8_datapath
  import pwm8_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int CW  = CNT_W,
  parameter int PW  = PS_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               dpCtl,
  input  logic                 fixTick,
  input  logic                 extTick,
  input  logic [CW-1:0]        modReg,
  input  logic [CW-1:0]        cntInit,
  input  logic [NCH-1:0][CW:0] cmpReg,
  input  logic [NCH-1:0]       chMode,
  input  logic [NCH-1:0]       outInit,
  input  logic [NCH-1:0]       polReg,
  input  logic [NCH-1:0]       maskReg,
  input  logic [NCH-1:0]       chEn,
  output logic [CW-1:0]        cntVal,
  output logic                 cntEn,
  output logic                 wrapNow,
  output logic [CW-1:0]        modAct,
  output logic [NCH-1:0]       pwmOut
);
  localparam int PSC_W = (1 << PW) - 1;

  logic [PSC_W-1:0]     psCnt;
  logic [PSC_W-1:0]     psMask;
  logic                 srcTick;
  logic [NCH-1:0][CW:0] cmpAct;

  always_comb begin
    case (dpCtl.srcSel)
      2'd1:    srcTick = 1'b1;
      2'd2:    srcTick = fixTick;
      2'd3:    srcTick = extTick;
      default: srcTick = 1'b0;
    endcase
  end

  assign psMask  = (PSC_W'(1) << dpCtl.psSel) - PSC_W'(1);
  assign cntEn   = dpCtl.running && srcTick && ((psCnt & psMask) == psMask);
  assign wrapNow = cntEn && (cntVal >= modAct);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psCnt  <= '0;
      cntVal <= '0;
      modAct <= '1;
      cmpAct <= '0;
    end else begin
      if (!dpCtl.running)  psCnt <= '0;
      else if (srcTick)    psCnt <= psCnt + PSC_W'(1);

      if (!dpCtl.running)  cntVal <= cntInit;
      else if (wrapNow)    cntVal <= cntInit;
      else if (cntEn)      cntVal <= cntVal + CW'(1);

      if (!dpCtl.running || wrapNow) begin
        modAct <= modReg;
        cmpAct <= cmpReg;
      end
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic level;
    assign level = dpCtl.running ? (chMode[ch] && ({1'b0, cntVal} < cmpAct[ch]))
                                 : outInit[ch];
    always_ff @(posedge clk) begin
      if (!rstN) pwmOut[ch] <= 1'b0;
      else       pwmOut[ch] <= (chEn[ch] && !maskReg[ch]) ? (level ^ polReg[ch]) : 1'b0;
    end
  end
endmodule

// File: rtl/octa_pwm_timer.sv
module octa_pwm_timer
  import pwm8_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int CW  = CNT_W,
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           fixTick,
  input  logic           extTick,
  input  logic           busWr,
  input  logic [AW-1:0]  busAddr,
  input  logic [DW-1:0]  busWData,
  output logic [DW-1:0]  busRData,
  output logic [NCH-1:0] pwmOut
);
  dpCtl_t               dpCtl;
  logic [CW-1:0]        modReg, cntInit, cntVal, modAct;
  logic [NCH-1:0]       outInit, maskReg, polReg, chEn, chMode;
  logic [NCH-1:0][CW:0] cmpReg;
  logic                 locked, cntEn, wrapNow;

  pwm8_ctrl #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .cntVal(cntVal),
    .dpCtl(dpCtl), .modReg(modReg), .cntInit(cntInit), .outInit(outInit),
    .maskReg(maskReg), .polReg(polReg), .chEn(chEn), .chMode(chMode),
    .cmpReg(cmpReg), .locked(locked)
  );

  pwm8_datapath #(.NCH(NCH), .CW(CW), .PW(PS_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .fixTick(fixTick), .extTick(extTick),
    .modReg(modReg), .cntInit(cntInit), .cmpReg(cmpReg), .chMode(chMode),
    .outInit(outInit), .polReg(polReg), .maskReg(maskReg), .chEn(chEn),
    .cntVal(cntVal), .cntEn(cntEn), .wrapNow(wrapNow), .modAct(modAct),
    .pwmOut(pwmOut)
  );
endmodule

// File: rtl/octa_pwm_timer_chk.sv
module octa_pwm_timer_chk #(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           busWr,
  input logic [AW-1:0]  busAddr,
  input logic           locked,
  input logic [CW-1:0]  modReg,
  input logic [CW-1:0]  cntVal,
  input logic [CW-1:0]  cntInit,
  input logic           running,
  input logic           cntEn,
  input logic           wrapNow,
  input logic [CW-1:0]  modAct,
  input logic [NCH-1:0] maskReg,
  input logic [NCH-1:0] chEn,
  input logic [NCH-1:0] pwmOut
);
  AST_STOP_HOLDS_INIT: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> (cntVal == $past(cntInit))); // R2

  AST_WRAP_TO_INIT: assert property (@(posedge clk) disable iff (!rstN)
    (running && cntEn && cntVal >= modAct) |=> (cntVal == $past(cntInit))); // R3

  AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (running && !cntEn) |=> $stable(cntVal)); // R5

  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    (|maskReg) |=> ((pwmOut & $past(maskReg)) == '0)); // R9

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (~chEn != '0) |=> ((pwmOut & ~$past(chEn)) == '0)); // R9

  AST_LOCK_GUARDS_MOD: assert property (@(posedge clk) disable iff (!rstN)
    (locked && busWr && busAddr == 8'h08) |=> $stable(modReg)); // R10

  AST_MOD_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (running && !wrapNow) |=> $stable(modAct)); // R11
endmodule

bind octa_pwm_timer octa_pwm_timer_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .locked(locked),
  .modReg(modReg), .cntVal(cntVal), .cntInit(cntInit), .running(dpCtl.running),
  .cntEn(cntEn), .wrapNow(wrapNow), .modAct(modAct), .maskReg(maskReg),
  .chEn(chEn), .pwmOut(pwmOut)
);

// File: tb/tb_octa_pwm_timer.sv
module tb_octa_pwm_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fixTick = 1'b0;
  logic        extTick = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic [7:0]  pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  octa_pwm_timer dut (
    .clk(clk), .rstN(rstN), .fixTick(fixTick), .extTick(extTick),
    .busWr(busWr), .busAddr(busAddr), .busWData(busWData),
    .busRData(busRData), .pwmOut(pwmOut)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRData;
  endtask

  function automatic logic [31:0] ctrlWord(input logic [7:0] en, input logic [1:0] src,
                                            input logic [2:0] ps);
    return {8'h0, en, 11'h0, src, ps};
  endfunction

  // cycles from one entry into counter 0 to the next
  task automatic measPeriod(output int n);
    logic [31:0] v;
    n = 0;
    do begin @(negedge clk); rd(8'h04, v); end while (v == 0);
    do begin @(negedge clk); rd(8'h04, v); end while (v != 0);
    do begin @(negedge clk); rd(8'h04, v); n++; end while (v == 0 && n < 400);
    while (v != 0 && n < 400) begin @(negedge clk); rd(8'h04, v); n++; end
  endtask

  task automatic countHigh(input int ch, input int cyc, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pwmOut[ch]) n++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    @(negedge clk);
    check("R1 outputs", pwmOut, 0);
    rd(8'h14, v); check("R1 mask", v, 32'hFF);
    rd(8'h00, v); check("R1 ctrl", v, 0);
    rd(8'h08, v); check("R1 mod", v, 32'hFFFF);
    rd(8'h1C, v); check("R1 lock", v, 0);
  endtask

  task automatic t_stopped;
    logic [31:0] v;
    wr(8'h0C, 32'd5);
    repeat (4) @(negedge clk);
    rd(8'h04, v); check("R2 stopped count", v, 5);
    wr(8'h0C, 32'd0);
    @(negedge clk);
    rd(8'h04, v); check("R2 follows init", v, 0);
  endtask

  task automatic t_duty;
    int n;
    wr(8'h08, 32'd9);
    for (int ch = 0; ch < 8; ch++) wr(8'h40 + 8'(4*ch), (ch == 6) ? 32'd0 : 32'd1);
    wr(8'h60, 32'd3);            // ch0
    wr(8'h64, 32'd0);            // ch1
    wr(8'h68, 32'd10);           // ch2, above MOD
    wr(8'h6C, 32'd3);            // ch3 inverted
    wr(8'h70, 32'd5);            // ch4 masked
    wr(8'h74, 32'd5);            // ch5 disabled
    wr(8'h78, 32'd5);            // ch6 mode off
    wr(8'h18, 32'h08);
    wr(8'h14, 32'h90);
    wr(8'h00, ctrlWord(8'h5F, 2'd1, 3'd0));
    repeat (30) @(negedge clk);
    countHigh(0, 10, n); check("R6 ch0 duty", n, 3);
    countHigh(1, 10, n); check("R7 zero compare", n, 0);
    countHigh(2, 10, n); check("R7 compare above mod", n, 10);
    countHigh(3, 10, n); check("R8 polarity", n, 7);
    countHigh(4, 10, n); check("R9 masked", n, 0);
    countHigh(5, 10, n); check("R9 not enabled", n, 0);
    countHigh(6, 10, n); check("R13 mode off", n, 0);
  endtask

  task automatic t_period;
    int n;
    measPeriod(n); check("R3 period", n, 10);
    wr(8'h00, ctrlWord(8'h5F, 2'd1, 3'd2));
    measPeriod(n); check("R4 prescale 4", n, 40);
    wr(8'h00, ctrlWord(8'h5F, 2'd1, 3'd0));
  endtask

  task automatic t_fixsrc;
    logic [31:0] c0, v;
    wr(8'h00, ctrlWord(8'h5F, 2'd2, 3'd0));
    @(negedge clk);
    rd(8'h04, c0);
    repeat (10) @(negedge clk);
    rd(8'h04, v); check("R5 no tick holds", v, c0);
    for (int i = 0; i < 4; i++) begin
      fixTick = 1'b1;
      @(negedge clk);
      fixTick = 1'b0;
      @(negedge clk);
    end
    rd(8'h04, v); check("R5 four ticks", v, (c0 + 4) % 10);
    wr(8'h00, ctrlWord(8'h5F, 2'd1, 3'd0));
  endtask

  task automatic t_deferred;
    logic [31:0] v;
    int mx, n;
    do begin @(negedge clk); rd(8'h04, v); end while (v != 2);
    wr(8'h08, 32'd19);
    mx = 0;
    n = 0;
    do begin
      @(negedge clk); rd(8'h04, v); n++;
      if (int'(v) > mx) mx = int'(v);
    end while (v != 0 && n < 100);
    check("R11 old period kept", mx, 9);
    measPeriod(n); check("R11 new period", n, 20);
  endtask

  task automatic t_init_out;
    wr(8'h00, ctrlWord(8'h5F, 2'd0, 3'd0));
    wr(8'h10, 32'h01);
    repeat (3) @(negedge clk);
    check("R12 stopped levels", pwmOut, 8'h09);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    wr(8'h1C, 32'h1);
    rd(8'h1C, v); check("R10 lock set", v, 1);
    wr(8'h08, 32'd5);
    wr(8'h10, 32'h00);
    rd(8'h08, v); check("R10 mod ignored", v, 19);
    @(negedge clk);
    check("R10 init ignored", pwmOut, 8'h09);
    wr(8'h14, 32'hFF);
    rd(8'h14, v); check("R10 mask writable", v, 32'hFF);
    wr(8'h20, 32'h1);
    rd(8'h1C, v); check("R10 lock cleared", v, 0);
    wr(8'h08, 32'd5);
    rd(8'h08, v); check("R10 mod after unlock", v, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_stopped();
    t_duty();
    t_period();
    t_fixsrc();
    t_deferred();
    t_init_out();
    t_lock();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule